// File: doc/BRIEF.md
# Pipelined no-turnaround synchronous SRAM

A synchronous memory model that takes a read, a write or a deselect on every accepted rising clock edge and never needs an idle cycle between a read and a write. A read returns its data two accepted edges after the command. A write gives its address with the command and its data two accepted edges later. Because write data lags its address, the model keeps the addresses of writes still waiting for data in a two-deep registry. A read of an address whose data arrives on the same edge is served from the data-in bus, not from the array.

Commands are either loaded from the address bus or continued as a four-beat burst on the low two address bits, in linear or interleaved order. A clock enable stalls the whole pipeline. A sleep input freezes the block and keeps the bus quiet. The bidirectional bus is split into `dq_i`, `dq_o` and `dq_oe_o`.

Top module: `nt_sram`

## Requirements
- R1: A read command accepted on edge E0 places the addressed word on `dq_o` after the next accepted edge E1, with `dq_oe_o` high while `oe_ni` is low, and holds it until the edge after that.
- R2: An edge with `cen_ni` high is ignored. No write happens, the command, burst and pipeline state hold, and `dq_o` and the drive state keep their values.
- R3: For a write command accepted on edge E0, `dq_i` is sampled on the second accepted edge E2. Lane l is bits [9l+8:9l], and it is written only when `bw_ni[l]` is low.
- R4: A read accepted on the edge right after a write to the same address returns the new lanes of that write taken from `dq_i`, merged with the old contents of the lanes the write did not select.
- R5: A write with all of `bw_ni` high leaves the array unchanged. On a read, `bw_ni` has no effect.
- R6: With `adv_ld_i` low, a command selects the memory only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. Otherwise it is a deselect. With `adv_ld_i` high after a deselect, the block stays deselected whatever the enables are.
- R7: With `adv_ld_i` high after a read or write, the same operation continues. The upper address bits come from the loaded address. For beat n (1..3), the low two bits are (base+n) mod 4 when `ilv_i`=0 and base xor n when `ilv_i`=1.
- R8: `dq_oe_o` is low whenever write data is due on `dq_i` before the next accepted edge, whatever `oe_ni` is. `dq_oe_o` is also low while `oe_ni` is high.
- R9: While `zz_i` is high, edges are ignored as under R2 and `dq_oe_o` is low. After `zz_i` falls, `dq_oe_o` stays low until new read data reaches the output.
- R10: After reset, `dq_oe_o` and `dq_o` are zero and the pipeline holds no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| we_ni | input | 1 | Write enable, active low |
| bw_ni | input | LANES | Per-lane write selects, active low |
| adv_ld_i | input | 1 | 1 continues the burst, 0 loads a new command |
| ilv_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| zz_i | input | 1 | Sleep request |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | LANES*LANE_W | Write data in |
| dq_o | output | LANES*LANE_W | Registered read data |
| dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The assertions assume that `zz_i` is raised only after the pipeline has drained: both registry stages hold no command and the output register holds no read. They also assume that the write data on `dq_i` stays in place across stalled edges until the edge that takes it. The stimulus meets the first by issuing three accepted deselects before each sleep request. It meets the second by driving `dq_i` from the pending write in its own model on every cycle, including stalled ones. Randomised traffic reuses the previous address often, so that forwarding, partial-lane writes, write aborts and burst continuations of deselects all occur next to stalls and output-enable toggles.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/nt_sram_cmd.sv
module nt_sram_cmd
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              adv_ld_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o
);
  localparam logic [BURST_W-1:0] ONE = {{(BURST_W-1){1'b0}}, 1'b1};

  op_e                last_op_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nx, ofs;
  logic               sel;

  assign sel    = !ce1_ni && ce2_i && !ce3_ni;
  assign cnt_nx = cnt_q + ONE;
  assign ofs    = ilv_i ? (base_q[BURST_W-1:0] ^ cnt_nx)
                        : (base_q[BURST_W-1:0] + cnt_nx);

  always_comb begin
    if (!adv_ld_i) begin
      op_o   = sel ? (we_ni ? OP_RD : OP_WR) : OP_NONE;
      addr_o = addr_i;
    end else begin
      op_o   = last_op_q;
      addr_o = {base_q[ADDR_W-1:BURST_W], ofs};
    end
    be_o = (op_o == OP_WR) ? ~bw_ni : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_op_q <= OP_NONE;
      base_q    <= '0;
      cnt_q     <= '0;
    end else if (step_i) begin
      last_op_q <= op_o;
      if (!adv_ld_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_nx;
      end
    end
  end

  assert_desel_continue_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && adv_ld_i && last_op_q == OP_NONE) |=> (last_op_q == OP_NONE));

  assert_burst_base_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && adv_ld_i) |=> $stable(base_q));
endmodule

// File: rtl/nt_sram_wreg.sv
module nt_sram_wreg
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  op_e                     op_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] arr_rd_i,
  input  logic [LANES*LANE_W-1:0] din_i,
  output op_e                     s1_op_o,
  output logic [ADDR_W-1:0]       s1_addr_o,
  output op_e                     s2_op_o,
  output logic [ADDR_W-1:0]       s2_addr_o,
  output logic [LANES-1:0]        s2_be_o,
  output logic [LANES*LANE_W-1:0] rd_data_o
);
  localparam int STAGES = 2;
  localparam int LAST   = STAGES - 1;

  op_e               op_q   [STAGES];
  logic [ADDR_W-1:0] addr_q [STAGES];
  logic [LANES-1:0]  be_q   [STAGES];
  logic              hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) begin
        op_q[i]   <= OP_NONE;
        addr_q[i] <= '0;
        be_q[i]   <= '0;
      end
    end else if (step_i) begin
      op_q[0]   <= op_i;
      addr_q[0] <= addr_i;
      be_q[0]   <= be_i;
      for (int i = 1; i < STAGES; i++) begin
        op_q[i]   <= op_q[i-1];
        addr_q[i] <= addr_q[i-1];
        be_q[i]   <= be_q[i-1];
      end
    end
  end

  assign s1_op_o   = op_q[0];
  assign s1_addr_o = addr_q[0];
  assign s2_op_o   = op_q[LAST];
  assign s2_addr_o = addr_q[LAST];
  assign s2_be_o   = be_q[LAST];

  // write whose data lands on this edge targets the word being read
  assign hit = (op_q[LAST] == OP_WR) && (addr_q[LAST] == addr_q[0]);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign rd_data_o[l*LANE_W +: LANE_W] = (hit && be_q[LAST][l])
                                         ? din_i[l*LANE_W +: LANE_W]
                                         : arr_rd_i[l*LANE_W +: LANE_W];
  end

  assert_registry_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(op_q[LAST]) && $stable(addr_q[LAST]) && $stable(be_q[LAST])));
endmodule

// File: rtl/nt_sram_array.sv
module nt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) mem_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/nt_sram.sv
module nt_sram
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cen_ni,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic                    adv_ld_i,
  input  logic                    ilv_i,
  input  logic                    oe_ni,
  input  logic                    zz_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              step;
  op_e               cmd_op, s1_op, s2_op;
  logic [ADDR_W-1:0] cmd_addr, s1_addr, s2_addr;
  logic [LANES-1:0]  cmd_be, s2_be;
  logic [DATA_W-1:0] arr_rd, rd_fwd, dout_q;
  logic              rd_vld_q;

  assign step = !cen_ni && !zz_i;

  nt_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(2)) u_cmd (
    .clk_i, .rst_ni, .step_i(step),
    .ce1_ni, .ce2_i, .ce3_ni, .we_ni, .bw_ni, .adv_ld_i, .ilv_i, .addr_i,
    .op_o(cmd_op), .addr_o(cmd_addr), .be_o(cmd_be)
  );

  nt_sram_wreg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wreg (
    .clk_i, .rst_ni, .step_i(step),
    .op_i(cmd_op), .addr_i(cmd_addr), .be_i(cmd_be),
    .arr_rd_i(arr_rd), .din_i(dq_i),
    .s1_op_o(s1_op), .s1_addr_o(s1_addr),
    .s2_op_o(s2_op), .s2_addr_o(s2_addr), .s2_be_o(s2_be),
    .rd_data_o(rd_fwd)
  );

  nt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i,
    .we_i(step && s2_op == OP_WR), .be_i(s2_be), .waddr_i(s2_addr),
    .wdata_i(dq_i), .raddr_i(s1_addr), .rdata_o(arr_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q   <= '0;
      rd_vld_q <= 1'b0;
    end else if (zz_i) begin
      rd_vld_q <= 1'b0;
    end else if (step) begin
      dout_q   <= rd_fwd;
      rd_vld_q <= (s1_op == OP_RD);
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = rd_vld_q && !oe_ni && !zz_i;

  assert_wr_phase_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_op == OP_WR) |-> !rd_vld_q);

  assert_stall_output_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step |=> $stable(dq_o));

  assert_sleep_exit_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(zz_i) |-> !rd_vld_q);

  assert_sleep_entry_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(zz_i) |-> (s1_op == OP_NONE && s2_op == OP_NONE && !rd_vld_q));
endmodule

// File: tb/sim_nt_sram.sv
`timescale 1ns/1ps
module sim_nt_sram;
  localparam int AW = 6;
  localparam int L  = 2;
  localparam int LW = 9;
  localparam int DW = L * LW;
  localparam int OPN = 0, OPR = 1, OPW = 2;

  logic clk = 1'b0;
  logic rst_ni, cen_ni, ce1_ni, ce2_i, ce3_ni, we_ni, adv_ld_i, ilv_i, oe_ni, zz_i;
  logic [L-1:0]  bw_ni;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_oe_o;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] ref_mem [64];
  string         wtag    [64];
  int            st_op   [2];
  int            st_addr [2];
  logic [DW-1:0] st_val  [2];
  string         st_tag  [2];
  int            b_last, b_base, b_cnt;
  bit            stalled_prev, post_sleep;

  always #5 clk = ~clk;

  nt_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) u0 (
    .clk_i(clk), .rst_ni, .cen_ni, .ce1_ni, .ce2_i, .ce3_ni, .we_ni, .bw_ni,
    .adv_ld_i, .ilv_i, .oe_ni, .zz_i, .addr_i, .dq_i, .dq_o, .dq_oe_o
  );

  task automatic chk_out();
    bit    eo;
    string t;
    eo = (st_op[1] == OPR) && !oe_ni && !zz_i;
    if (st_op[1] == OPW)      t = "R8";
    else if (zz_i || post_sleep) t = "R9";
    else if (oe_ni)           t = "R8";
    else if (st_op[1] == OPN) t = "R6";
    else if (stalled_prev)    t = "R2";
    else                      t = "R1";
    checks++;
    if (dq_oe_o !== eo) begin
      fails++;
      $display("FAIL %s dq_oe_o actual=%0b expected=%0b", t, dq_oe_o, eo);
    end
    if (st_op[1] == OPR) begin
      t = stalled_prev ? "R2" : st_tag[1];
      checks++;
      if (dq_o !== st_val[1]) begin
        fails++;
        $display("FAIL %s dq_o actual=%h expected=%h", t, dq_o, st_val[1]);
      end
    end
  endtask

  task automatic cyc(bit cen, logic [2:0] ce, bit we, bit adv, logic [L-1:0] bw,
                     int a, bit oe, bit zz);
    int            op, na, nb, nc, lo;
    logic [DW-1:0] v, wd;
    string         tg;
    @(negedge clk);
    chk_out();
    post_sleep = 1'b0;
    if (!adv) begin
      op = (ce == 3'b010) ? (we ? OPW : OPR) : OPN;
      na = a; nb = a; nc = 0;
    end else begin
      op = b_last;
      nc = (b_cnt + 1) % 4;
      lo = ilv_i ? ((b_base % 4) ^ nc) : ((b_base + nc) % 4);
      na = (b_base / 4) * 4 + lo;
      nb = b_base;
    end
    wd = DW'($urandom);
    v  = '0;
    tg = "R6";
    if (op == OPW) begin
      v = ref_mem[na];
      for (int l = 0; l < L; l++) if (!bw[l]) v[l*LW +: LW] = wd[l*LW +: LW];
      tg = (bw == '1) ? "R5" : (adv ? "R7" : "R3");
    end else if (op == OPR) begin
      v = ref_mem[na];
      if (st_op[0] == OPW && st_addr[0] == na) tg = "R4";
      else if (adv)                            tg = "R7";
      else                                     tg = wtag[na];
    end
    cen_ni = cen;
    {ce1_ni, ce2_i, ce3_ni} = ce;
    we_ni    = !we;
    adv_ld_i = adv;
    bw_ni    = bw;
    addr_i   = AW'(a);
    oe_ni    = oe;
    zz_i     = zz;
    dq_i     = (st_op[1] == OPW) ? st_val[1] : DW'($urandom);
    @(posedge clk);
    if (!cen && !zz) begin
      if (op == OPW) begin
        ref_mem[na] = v;
        wtag[na]    = tg;
      end
      st_op[1] = st_op[0]; st_addr[1] = st_addr[0];
      st_val[1] = st_val[0]; st_tag[1] = st_tag[0];
      st_op[0] = op; st_addr[0] = na;
      st_val[0] = (op == OPW) ? wd : v;
      st_tag[0] = tg;
      b_last = op; b_base = nb; b_cnt = nc;
      stalled_prev = 1'b0;
    end else begin
      stalled_prev = 1'b1;
    end
  endtask

  task automatic rand_phase(int n);
    int prev_a;
    prev_a = 0;
    for (int i = 0; i < n; i++) begin
      bit cen, we, adv, oe;
      logic [2:0] ce;
      logic [L-1:0] bw;
      int a;
      cen = ($urandom % 100) < 15;
      ce  = (($urandom % 100) < 85) ? 3'b010 : 3'($urandom);
      we  = $urandom % 2;
      adv = ($urandom % 100) < 25;
      bw  = (($urandom % 8) == 0) ? '1 : ((($urandom % 2) == 1) ? '0 : L'($urandom));
      a   = (($urandom % 100) < 40) ? prev_a : int'($urandom % 64);
      oe  = ($urandom % 100) < 10;
      prev_a = a;
      cyc(cen, ce, we, adv, bw, a, oe, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin ref_mem[i] = '0; wtag[i] = "R1"; end
    for (int i = 0; i < 2; i++) begin st_op[i] = OPN; st_addr[i] = 0; st_val[i] = '0; st_tag[i] = "R1"; end
    b_last = OPN; b_base = 0; b_cnt = 0; stalled_prev = 0; post_sleep = 0;
    rst_ni = 1'b0; cen_ni = 1'b0; {ce1_ni, ce2_i, ce3_ni} = 3'b111; we_ni = 1'b1;
    adv_ld_i = 1'b0; ilv_i = 1'b0; oe_ni = 1'b0; zz_i = 1'b0; bw_ni = '1;
    addr_i = '0; dq_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    checks++;
    if (dq_oe_o !== 1'b0 || dq_o !== '0) begin
      fails++;
      $display("FAIL R10 reset actual=%0b/%h expected=0/0", dq_oe_o, dq_o);
    end

    // fill the array with linear bursts of four writes
    for (int g = 0; g < 16; g++) begin
      cyc(1'b0, 3'b010, 1'b1, 1'b0, '0, g * 4, 1'b0, 1'b0);
      for (int b = 0; b < 3; b++) cyc(1'b0, 3'b010, 1'b1, 1'b1, '0, 0, 1'b0, 1'b0);
    end

    ilv_i = 1'b0;
    rand_phase(1500);
    ilv_i = 1'b1;
    rand_phase(1500);

    // drain, then sleep with stray commands and stalls, then wake
    for (int i = 0; i < 3; i++) cyc(1'b0, 3'b111, 1'b0, 1'b0, '1, 0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++)
      cyc(1'($urandom % 2), 3'b010, 1'($urandom % 2), 1'b0, '0, 7, 1'b0, 1'b1);
    cyc(1'b0, 3'b111, 1'b0, 1'b0, '1, 0, 1'b0, 1'b0);
    post_sleep = 1'b1;
    cyc(1'b0, 3'b010, 1'b0, 1'b0, '1, 7, 1'b0, 1'b0);
    cyc(1'b0, 3'b010, 1'b0, 1'b1, '1, 0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 3'b111, 1'b0, 1'b0, '1, 0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule